// File: doc/BRIEF.md
# Compare-Match Timer

This block is a free-running up-counter with a single output-compare channel. The counter advances by one on every clock, rolls over from its all-ones value to zero, and raises a sticky overflow flag on the clock edge at which it reaches zero. Software can load the counter, the compare value and a 2-bit output-action field at any time through a single write port. It can also pulse a strobe that forces the output action without a real match.

Whenever the counter equals the compare value, the block raises a sticky match flag. On the same edge it applies the selected action to a waveform pin: hold, toggle, drive low or drive high. Both flags stay set until their acknowledge input is pulsed. An interrupt controller placed beside the block would use these flags and acknowledges.

Top module: `cmp_timer`

## Requirements
- R1: While `rst` is high, `count`, `ovf_flag`, `cmp_flag` and `wave_out` all read 0. The compare value resets to 0 and the output action resets to hold (00).
- R2: With no counter write, `count` rises by exactly one on every clock edge, and the value 0xFFFF is followed by 0x0000.
- R3: `ovf_flag` becomes 1 on the same edge at which `count` goes from 0xFFFF to 0x0000 by counting. The first cycle that shows `count` = 0 also shows the flag set.
- R4: `ovf_flag` stays set until `ack_ovf` is high at a clock edge. If an acknowledge and a new wrap happen at the same edge, the flag stays 1.
- R5: A write with `wr_addr` = 0 loads `wr_data` into the counter at that edge instead of the increment. A load never sets `ovf_flag`. A load also suppresses any compare match that the old counter value would have caused at that edge.
- R6: When `count` equals the compare value (written with `wr_addr` = 1) and no counter load occurs, `cmp_flag` is 1 from the next edge on. It is cleared only by `ack_cmp`, and if a match and `ack_cmp` happen at the same edge, the flag stays set.
- R7: The output action is written with `wr_addr` = 2 into bits [1:0] of `wr_data`. 00 leaves `wave_out` unchanged, 01 inverts it, 10 drives it to 0 and 11 drives it to 1. The action is applied on the edge at which the match flag is set.
- R8: Writing a new output action does not change `wave_out` by itself. The new action first shows at the next compare match or forced compare.
- R9: A one-cycle pulse on `force_cmp` applies the current action to `wave_out` at that edge and does not set `cmp_flag`. With action 00 it leaves the pin unchanged. A force that coincides with a real match applies the action only once.
- R10: Writing the output action, or forcing a compare, never changes the counting sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Register select: 0 counter, 1 compare value, 2 output action, 3 unused |
| wr_data | input | 16 | Write data |
| force_cmp | input | 1 | Forced-compare strobe |
| ack_ovf | input | 1 | Clears the overflow flag |
| ack_cmp | input | 1 | Clears the match flag |
| count | output | 16 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |
| cmp_flag | output | 1 | Sticky compare-match flag |
| wave_out | output | 1 | Compare output pin |

## Verification
The bench checks the wrap edge cycle by cycle. A design that raised the overflow flag one cycle late, or on a software load of zero, would show `count` = 0 with a clear flag, or a set flag after a load. It hits acknowledge and event on the same edge for both flags, where clear-wins logic would drop a real event.

It loads the counter exactly while a match is pending, which a design without load blocking would flag. A force coinciding with a match catches a double toggle. Mode writes between matches catch a design that applies the action on the write itself.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_COUNT = 2'd0;
  localparam logic [ADDR_W-1:0] REG_CMP   = 2'd1;
  localparam logic [ADDR_W-1:0] REG_MODE  = 2'd2;

  typedef enum logic [1:0] {
    OUTM_HOLD   = 2'b00,
    OUTM_TOGGLE = 2'b01,
    OUTM_LOW    = 2'b10,
    OUTM_HIGH   = 2'b11
  } outm_e;
endpackage

// File: rtl/tmr_count_unit.sv
module tmr_count_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         ack_ovf,
  output logic [W-1:0] cnt_q,
  output logic         ovf_q
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};
  localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

  logic wrap;
  assign wrap = !load && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else begin
      cnt_q <= cnt_q + CNT_ONE;
    end
  end

  // a new wrap outranks the acknowledge
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_q <= 1'b0;
    end else if (wrap) begin
      ovf_q <= 1'b1;
    end else if (ack_ovf) begin
      ovf_q <= 1'b0;
    end
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q == $past(cnt_q) + CNT_ONE));

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q == CNT_MAX) |=> (ovf_q && cnt_q == '0));

  // R4
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ack_ovf) |=> ovf_q);

  // R5
  ovf_load_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !ovf_q) |=> !ovf_q);
endmodule

// File: rtl/tmr_match_unit.sv
module tmr_match_unit
  import cmp_timer_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt,
  input  logic         cnt_load,
  input  logic         cmp_wr,
  input  logic         mode_wr,
  input  logic [W-1:0] wdata,
  input  logic         ack_cmp,
  output logic         hit,
  output outm_e        mode_q,
  output logic         flag_q
);
  logic [W-1:0] cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q  <= '0;
      mode_q <= OUTM_HOLD;
    end else begin
      if (cmp_wr) begin
        cmp_q <= wdata;
      end
      if (mode_wr) begin
        mode_q <= outm_e'(wdata[1:0]);
      end
    end
  end

  // a counter load in the same cycle blocks the match
  assign hit = (cnt == cmp_q) && !cnt_load;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else if (hit) begin
      flag_q <= 1'b1;
    end else if (ack_cmp) begin
      flag_q <= 1'b0;
    end
  end

  // R6
  cmp_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(cnt == cmp_q && !cnt_load));

  // R6
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ack_cmp) |=> flag_q);
endmodule

// File: rtl/tmr_wave_unit.sv
module tmr_wave_unit
  import cmp_timer_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  hit,
  input  logic  force_cmp,
  input  outm_e mode,
  output logic  wave_q
);
  logic act;
  assign act = hit || force_cmp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
    end else if (act) begin
      case (mode)
        OUTM_TOGGLE: wave_q <= ~wave_q;
        OUTM_LOW:    wave_q <= 1'b0;
        OUTM_HIGH:   wave_q <= 1'b1;
        default:     wave_q <= wave_q;
      endcase
    end
  end

  // R8
  wave_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !act |=> $stable(wave_q));

  // R7
  wave_high_chk: assert property (@(posedge clk) disable iff (rst)
    (act && mode == OUTM_HIGH) |=> wave_q);

  // R7
  wave_low_chk: assert property (@(posedge clk) disable iff (rst)
    (act && mode == OUTM_LOW) |=> !wave_q);
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             force_cmp,
  input  logic             ack_ovf,
  input  logic             ack_cmp,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             cmp_flag,
  output logic             wave_out
);
  logic  cnt_load;
  logic  cmp_wr;
  logic  mode_wr;
  logic  hit;
  outm_e mode;

  assign cnt_load = wr_en && (wr_addr == REG_COUNT);
  assign cmp_wr   = wr_en && (wr_addr == REG_CMP);
  assign mode_wr  = wr_en && (wr_addr == REG_MODE);

  tmr_count_unit #(.W(CNT_W)) u_count (
    .clk      (clk),
    .rst      (rst),
    .load     (cnt_load),
    .load_val (wr_data),
    .ack_ovf  (ack_ovf),
    .cnt_q    (count),
    .ovf_q    (ovf_flag)
  );

  tmr_match_unit #(.W(CNT_W)) u_match (
    .clk      (clk),
    .rst      (rst),
    .cnt      (count),
    .cnt_load (cnt_load),
    .cmp_wr   (cmp_wr),
    .mode_wr  (mode_wr),
    .wdata    (wr_data),
    .ack_cmp  (ack_cmp),
    .hit      (hit),
    .mode_q   (mode),
    .flag_q   (cmp_flag)
  );

  tmr_wave_unit u_wave (
    .clk       (clk),
    .rst       (rst),
    .hit       (hit),
    .force_cmp (force_cmp),
    .mode      (mode),
    .wave_q    (wave_out)
  );

  // R9
  force_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (force_cmp && !hit && !cmp_flag) |=> !cmp_flag);
endmodule

// File: tb/cmp_timer_test.sv
`timescale 1ns/1ps
module cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        force_cmp = 1'b0;
  logic        ack_ovf = 1'b0;
  logic        ack_cmp = 1'b0;
  logic [15:0] count;
  logic        ovf_flag;
  logic        cmp_flag;
  logic        wave_out;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .force_cmp(force_cmp), .ack_ovf(ack_ovf), .ack_cmp(ack_cmp),
    .count(count), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .wave_out(wave_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every task starts and ends at a falling edge
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input logic o, input logic c);
    ack_ovf = o; ack_cmp = c;
    @(negedge clk);
    ack_ovf = 1'b0; ack_cmp = 1'b0;
  endtask

  task automatic pulse_force();
    force_cmp = 1'b1;
    @(negedge clk);
    force_cmp = 1'b0;
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1 count", count, 0);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 cmp", cmp_flag, 0);
    chk("R1 wave", wave_out, 0);
    rst = 1'b0;
    idle(1);
    chk("R1 first count", count, 1);
  endtask

  task automatic t_wrap();
    ack(1'b1, 1'b1);
    wr(2'd0, 16'hFFFD);
    chk("R5 load", count, 16'hFFFD);
    idle(1);
    chk("R2 step", count, 16'hFFFE);
    idle(1);
    chk("R2 max", count, 16'hFFFF);
    chk("R3 before wrap", ovf_flag, 0);
    idle(1);
    chk("R2 wrap", count, 0);
    chk("R3 wrap flag", ovf_flag, 1);
    idle(1);
    chk("R2 after wrap", count, 1);
  endtask

  task automatic t_ovf_sticky();
    idle(5);
    chk("R4 sticky", ovf_flag, 1);
    ack(1'b1, 1'b0);
    chk("R4 ack clears", ovf_flag, 0);
    wr(2'd0, 16'hFFFE);
    idle(2);
    chk("R4 reset flag", ovf_flag, 1);
    wr(2'd0, 16'hFFFF);
    ack(1'b1, 1'b0);
    chk("R4 set wins count", count, 0);
    chk("R4 set wins", ovf_flag, 1);
  endtask

  task automatic t_load();
    ack(1'b1, 1'b0);
    wr(2'd0, 16'hFFFF);
    wr(2'd0, 16'h1234);
    chk("R5 load over max", count, 16'h1234);
    chk("R5 no ovf from load", ovf_flag, 0);
  endtask

  task automatic t_match_toggle();
    wr(2'd1, 16'h0100);
    wr(2'd2, 16'h0001);
    ack(1'b0, 1'b1);
    wr(2'd0, 16'h00FE);
    idle(2);
    chk("R6 at compare value", cmp_flag, 0);
    chk("R8 not yet", wave_out, 0);
    idle(1);
    chk("R6 flag set", cmp_flag, 1);
    chk("R7 toggle high", wave_out, 1);
    idle(3);
    chk("R6 sticky", cmp_flag, 1);
    ack(1'b0, 1'b1);
    chk("R6 ack clears", cmp_flag, 0);
    wr(2'd0, 16'h00FF);
    idle(1);
    ack(1'b0, 1'b1);
    chk("R6 set wins", cmp_flag, 1);
    chk("R7 toggle low", wave_out, 0);
  endtask

  task automatic t_modes();
    wr(2'd2, 16'h0003);
    chk("R8 write no effect", wave_out, 0);
    idle(2);
    chk("R8 still no effect", wave_out, 0);
    wr(2'd0, 16'h00FF);
    idle(2);
    chk("R8 applied at match", wave_out, 1);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h00FF);
    idle(2);
    chk("R7 hold", wave_out, 1);
    wr(2'd2, 16'h0002);
    chk("R8 clear pending", wave_out, 1);
    wr(2'd0, 16'h00FF);
    idle(2);
    chk("R7 clear", wave_out, 0);
  endtask

  task automatic t_block();
    ack(1'b0, 1'b1);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h00FF);
    idle(1);
    chk("R5 at compare", count, 16'h0100);
    wr(2'd0, 16'h0500);
    chk("R5 blocked flag", cmp_flag, 0);
    chk("R5 blocked wave", wave_out, 0);
    idle(1);
    chk("R5 blocked later", cmp_flag, 0);
  endtask

  task automatic t_force();
    pulse_force();
    chk("R9 force toggle", wave_out, 1);
    chk("R9 force no flag", cmp_flag, 0);
    wr(2'd2, 16'h0000);
    pulse_force();
    chk("R9 force hold", wave_out, 1);
    wr(2'd2, 16'h0002);
    pulse_force();
    chk("R9 force clear", wave_out, 0);
    wr(2'd2, 16'h0003);
    pulse_force();
    chk("R9 force set", wave_out, 1);
    chk("R9 still no flag", cmp_flag, 0);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h00FF);
    idle(1);
    pulse_force();
    chk("R9 force with match once", wave_out, 0);
    chk("R9 match flag kept", cmp_flag, 1);
  endtask

  task automatic t_mode_count();
    wr(2'd0, 16'h2000);
    chk("R10 base", count, 16'h2000);
    wr(2'd2, 16'h0003);
    chk("R10 after mode write", count, 16'h2001);
    wr(2'd2, 16'h0001);
    chk("R10 after second write", count, 16'h2002);
    pulse_force();
    chk("R10 after force", count, 16'h2003);
    idle(3);
    chk("R10 runs on", count, 16'h2006);
  endtask

  initial begin
    t_reset();
    t_wrap();
    t_ovf_sticky();
    t_load();
    t_match_toggle();
    t_modes();
    t_block();
    t_force();
    t_mode_count();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule